// File: doc/BRIEF.md
# Per-Block Write-Protection Lock Bank

This block holds one small lock register for every erase block of a sectored nonvolatile memory and turns those registers, together with two active-low hardware protect inputs, into a yes/no decision for each program or erase request. Every register stores two meaningful bits. The write-lock bit refuses program and erase. The lock-down bit freezes the register until the next reset.

Software reads and writes the registers through a plain indexed port. The write port is accepted in every cycle and has no back-pressure. The read port is combinational. When the memory controller is about to start an operation, it pulses a start strobe with the block index. One cycle later the bank answers with a valid pulse and a one-hot grant vector. The decision uses the lock state present in the start cycle, so a register write in that same cycle does not change it.

Two reset inputs return every register to its power-up state. Asserting either one is enough. The top-boot pin protects the highest-indexed block. The write-protect pin protects blocks 0 through `WP_LAST`. Neither pin is visible in readback.

Top module: `blklock_bank`

## Requirements
- R1: While `rst_n` or `init_n` is low, and afterwards until written, every register reads 0x01 (write-locked, not locked down), so no block is granted.
- R2: Readback bits 7 to 2 are always zero, whatever value was written. A read with an index of `NUM_BLOCKS` or above returns 0x00.
- R3: A write to a register whose lock-down bit (bit 1) is clear stores data bits 1:0. Bit 0 is write-lock and bit 1 is lock-down. The new value is visible on the read port in the cycle after the write edge.
- R4: Once bit 1 of a register is set, every later write to that register is ignored, and its write-lock bit keeps its value.
- R5: Lock-down is cleared only by reset. A low pulse on `rst_n` alone, or on `init_n` alone, returns every register to 0x01.
- R6: A cycle with `op_start` high is followed, one cycle later, by `op_vld` high. In that cycle `op_grant` has only bit `op_idx` set when that block is permitted, and is all zero otherwise. `op_grant` is zero whenever `op_vld` is low.
- R7: While `tbl_n` is low, block `NUM_BLOCKS-1` is refused whatever its register holds. Other blocks are unaffected.
- R8: While `wp_n` is low, blocks 0 to `WP_LAST` are refused whatever their registers hold. The top block is unaffected.
- R9: Readback never reflects `tbl_n` or `wp_n`.
- R10: The decision is taken from the lock state before the edge that ends the start cycle. A write to the same block in the start cycle affects only later operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Device reset, active low, asynchronous |
| init_n | input | 1 | Second device reset, active low, asynchronous |
| tbl_n | input | 1 | Top-boot protect, active low |
| wp_n | input | 1 | Protect for blocks 0..WP_LAST, active low |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | IDX_W | Register index for the write |
| wr_data | input | 8 | Write data; only bits 1:0 are stored |
| rd_idx | input | IDX_W | Register index for the read |
| rd_data | output | 8 | Combinational readback |
| op_start | input | 1 | Operation-start strobe |
| op_idx | input | IDX_W | Block addressed by the operation |
| op_vld | output | 1 | Decision valid, one cycle after op_start |
| op_grant | output | NUM_BLOCKS | One-hot permit for the addressed block |

## Verification
The grant path is tried with each of the four register encodings on several blocks. This separates the effect of write-lock from the effect of lock-down, and shows that a locked-down open block stays grantable. Each hardware pin is driven low on its own against fully unlocked registers, with probes on both sides of its range: blocks 0 and `WP_LAST`, and the top block. These show that each pin covers only its range and that readback stays unchanged. A write issued in the same cycle as a start strobe shows that the decision uses the state before the write. Separate pulses on each reset input show that either one alone clears lock-down.

// File: rtl/blklock_pkg.sv
package blklock_pkg;
  localparam int REG_W = 8;

  typedef struct packed {
    logic ld;  // bit 1: lock-down
    logic wl;  // bit 0: write-lock
  } lock_t;

  localparam lock_t LOCK_PWRUP = '{ld: 1'b0, wl: 1'b1};
endpackage

// File: rtl/blklock_cell.sv
module blklock_cell
  import blklock_pkg::*;
(
  input  logic  clk,
  input  logic  arst_n,
  input  logic  wr_hit,
  input  lock_t wr_val,
  output lock_t q
);
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)             q <= LOCK_PWRUP;
    else if (wr_hit && !q.ld) q <= wr_val;
  end

  AST_LD_STICKY: assert property (@(posedge clk) disable iff (!arst_n)
    q.ld |=> q.ld); // R4
  AST_LD_FREEZES_WL: assert property (@(posedge clk) disable iff (!arst_n)
    q.ld |=> $stable(q.wl)); // R4
endmodule

// File: rtl/blklock_override.sv
module blklock_override #(
  parameter int NUM_BLOCKS = 8,
  parameter int WP_LAST    = 6
) (
  input  logic [NUM_BLOCKS-1:0] wl_vec,
  input  logic                  tbl_n,
  input  logic                  wp_n,
  output logic [NUM_BLOCKS-1:0] refuse
);
  localparam int TOP = NUM_BLOCKS - 1;

  for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_blk
    if (i == TOP) begin : g_top
      assign refuse[i] = wl_vec[i] | ~tbl_n;
    end else if (i <= WP_LAST) begin : g_wp
      assign refuse[i] = wl_vec[i] | ~wp_n;
    end else begin : g_plain
      assign refuse[i] = wl_vec[i];
    end
  end
endmodule

// File: rtl/blklock_permit.sv
module blklock_permit #(
  parameter int NUM_BLOCKS = 8,
  parameter int IDX_W      = 3
) (
  input  logic                  clk,
  input  logic                  arst_n,
  input  logic                  op_start,
  input  logic [IDX_W-1:0]      op_idx,
  input  logic [NUM_BLOCKS-1:0] refuse,
  output logic                  vld_q,
  output logic [NUM_BLOCKS-1:0] grant_q
);
  logic [NUM_BLOCKS-1:0] sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_BLOCKS; i++)
      if (op_idx == IDX_W'(i)) sel[i] = 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      vld_q   <= 1'b0;
      grant_q <= '0;
    end else begin
      vld_q   <= op_start;
      grant_q <= op_start ? (sel & ~refuse) : '0;
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!arst_n)
    $onehot0(grant_q)); // R6
  AST_VLD_FOLLOWS_START: assert property (@(posedge clk) disable iff (!arst_n)
    op_start |=> vld_q); // R6
  AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!arst_n)
    !vld_q |-> (grant_q == '0)); // R6
endmodule

// File: rtl/blklock_bank.sv
module blklock_bank
  import blklock_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int WP_LAST    = 6,
  localparam int IDX_W     = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  init_n,
  input  logic                  tbl_n,
  input  logic                  wp_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [REG_W-1:0]      wr_data,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [REG_W-1:0]      rd_data,
  input  logic                  op_start,
  input  logic [IDX_W-1:0]      op_idx,
  output logic                  op_vld,
  output logic [NUM_BLOCKS-1:0] op_grant
);
  localparam int TOP = NUM_BLOCKS - 1;

  logic                  arst_n;
  lock_t                 cell_q [NUM_BLOCKS];
  logic [NUM_BLOCKS-1:0] wl_vec;
  logic [NUM_BLOCKS-1:0] refuse;
  lock_t                 wr_val;

  assign arst_n = rst_n & init_n;
  assign wr_val = lock_t'(wr_data[1:0]);

  for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_cell
    blklock_cell u_cell (
      .clk    (clk),
      .arst_n (arst_n),
      .wr_hit (wr_en && (wr_idx == IDX_W'(i))),
      .wr_val (wr_val),
      .q      (cell_q[i])
    );
    assign wl_vec[i] = cell_q[i].wl;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_BLOCKS; i++)
      if (rd_idx == IDX_W'(i)) rd_data = {{(REG_W-2){1'b0}}, cell_q[i]};
  end

  blklock_override #(.NUM_BLOCKS(NUM_BLOCKS), .WP_LAST(WP_LAST)) u_ovr (
    .wl_vec (wl_vec),
    .tbl_n  (tbl_n),
    .wp_n   (wp_n),
    .refuse (refuse)
  );

  blklock_permit #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) u_permit (
    .clk      (clk),
    .arst_n   (arst_n),
    .op_start (op_start),
    .op_idx   (op_idx),
    .refuse   (refuse),
    .vld_q    (op_vld),
    .grant_q  (op_grant)
  );

  AST_TBL_REFUSES_TOP: assert property (@(posedge clk) disable iff (!arst_n)
    (op_start && !tbl_n) |=> !op_grant[TOP]); // R7
  AST_WP_REFUSES_LOW: assert property (@(posedge clk) disable iff (!arst_n)
    (op_start && !wp_n && (op_idx <= IDX_W'(WP_LAST))) |=> (op_grant == '0)); // R8
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!arst_n)
    rd_data[REG_W-1:2] == '0); // R2
endmodule

// File: tb/blklock_bank_tb_top.sv
module blklock_bank_tb_top;
  localparam int NB = 8;
  localparam int WPL = 6;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0, init_n = 1'b0, tbl_n = 1'b1, wp_n = 1'b1;
  logic wr_en = 1'b0, op_start = 1'b0;
  logic [IW-1:0] wr_idx = '0, rd_idx = '0, op_idx = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic op_vld;
  logic [NB-1:0] op_grant;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  blklock_bank #(.NUM_BLOCKS(NB), .WP_LAST(WPL)) dut_i (
    .clk(clk), .rst_n(rst_n), .init_n(init_n), .tbl_n(tbl_n), .wp_n(wp_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx),
    .rd_data(rd_data), .op_start(op_start), .op_idx(op_idx),
    .op_vld(op_vld), .op_grant(op_grant)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int idx, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(string tag, int idx, logic [7:0] exp);
    rd_idx = IW'(idx);
    #1;
    chk(tag, 32'(rd_data), 32'(exp));
  endtask

  task automatic op_chk(string tag, int idx, bit permit);
    @(negedge clk);
    op_start = 1'b1; op_idx = IW'(idx);
    @(negedge clk);
    op_start = 1'b0;
    chk({tag, " vld"}, 32'(op_vld), 32'd1);
    chk(tag, 32'(op_grant), permit ? (32'd1 << idx) : 32'd0);
  endtask

  task automatic t_reset;
    for (int i = 0; i < NB; i++) rd_chk("R1 reset value", i, 8'h01);
    op_chk("R1 locked after reset", 0, 1'b0);
    op_chk("R1 top locked after reset", NB-1, 1'b0);
    @(negedge clk);
    chk("R6 vld idle", 32'(op_vld), 32'd0);
  endtask

  task automatic t_write;
    wr(2, 8'hFC);
    rd_chk("R2 R3 reserved dropped", 2, 8'h00);
    op_chk("R3 R6 unlocked grant", 2, 1'b1);
    wr(2, 8'h01);
    rd_chk("R3 relock", 2, 8'h01);
    op_chk("R3 relocked refused", 2, 1'b0);
    rd_chk("R2 out-of-range index n/a (3 bits)", 7, 8'h01);
  endtask

  task automatic t_lockdown;
    wr(3, 8'h02);
    rd_chk("R3 locked open", 3, 8'h02);
    wr(3, 8'h01);
    rd_chk("R4 write ignored", 3, 8'h02);
    op_chk("R4 locked open grant", 3, 1'b1);
    wr(4, 8'h03);
    wr(4, 8'h00);
    rd_chk("R4 locked closed kept", 4, 8'h03);
    op_chk("R4 locked closed refused", 4, 1'b0);
  endtask

  task automatic t_resets;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd_chk("R5 rst_n clears", 3, 8'h01);
    rd_chk("R5 rst_n clears 4", 4, 8'h01);
    wr(5, 8'h02);
    @(negedge clk); init_n = 1'b0;
    @(negedge clk); init_n = 1'b1;
    rd_chk("R5 init_n clears", 5, 8'h01);
    wr(5, 8'h00);
    rd_chk("R5 writable again", 5, 8'h00);
  endtask

  task automatic t_tbl;
    for (int i = 0; i < NB; i++) wr(i, 8'h00);
    tbl_n = 1'b0;
    op_chk("R7 top refused", NB-1, 1'b0);
    op_chk("R7 block0 open", 0, 1'b1);
    op_chk("R7 block6 open", WPL, 1'b1);
    rd_chk("R9 top readback", NB-1, 8'h00);
    tbl_n = 1'b1;
    op_chk("R7 top open after release", NB-1, 1'b1);
  endtask

  task automatic t_wp;
    wp_n = 1'b0;
    op_chk("R8 block0 refused", 0, 1'b0);
    op_chk("R8 block6 refused", WPL, 1'b0);
    op_chk("R8 top open", NB-1, 1'b1);
    rd_chk("R9 block0 readback", 0, 8'h00);
    wp_n = 1'b1;
    op_chk("R8 block0 open after release", 0, 1'b1);
  endtask

  task automatic t_sample;
    @(negedge clk);
    op_start = 1'b1; op_idx = IW'(1);
    wr_en = 1'b1; wr_idx = IW'(1); wr_data = 8'h01;
    @(negedge clk);
    op_start = 1'b0; wr_en = 1'b0;
    chk("R10 old state used", 32'(op_grant), 32'd1 << 1);
    op_chk("R10 next op sees lock", 1, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rd_chk("R1 during reset", 0, 8'h01);
    rst_n = 1'b1; init_n = 1'b1;
    t_reset();
    t_write();
    t_lockdown();
    t_resets();
    t_tbl();
    t_wp();
    t_sample();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule